// File: doc/BRIEF.md
# Time-Slot Interchange Switch with Per-Channel Delay Modes

This block moves 8-bit channel samples between time slots of several serial streams that share one 32-slot frame. A connection word for every output stream and channel names the input stream and channel that supply it. It also carries a delay-mode bit and a loopback bit. Received samples go into a data store of three frame-sized banks. Each output slot is fetched from the bank its delay mode calls for.

In variable mode a channel takes the shortest path that still leaves three slot periods for the data to cross the switch. In constant mode every channel is read two frames after it was written, so a group of channels keeps its frame alignment. With the loopback bit set, what a transmit stream sends in a slot overwrites the receive sample of the same stream and slot, which is useful for diagnostics. Serial framing, host access and output enables sit outside the block. It sees parallel samples, a slot strobe and a frame strobe, plus a simple write port for connection words.

Top module: `tsi_switch`

## Requirements
- R1: While rst is high, tx_data is driven to all zeros on the next clock edge.
- R2: Slot strobes arriving before the first frame strobe after reset are ignored: tx_data stays zero and no sample is stored.
- R3: In variable mode (mode bit 0), output channel d in frame F carries input channel c of frame F when d >= c+3.
- R4: In variable mode, when d < c+3, output channel d in frame F carries input channel c of frame F-1 if c <= d+29, and of frame F-2 otherwise (c >= 30 with d <= c-30).
- R5: In constant mode (mode bit 1), output channel d in frame F carries input channel c of frame F-2 for every pair (c, d). Input slot 31 to output slot 0 is the shortest path and input slot 0 to output slot 31 the longest.
- R6: When the loopback bit of output stream s channel m is 1, the sample stored for input stream s channel m in that slot is the byte transmitted by stream s in that slot, and rx_data for it is ignored. When the bit is 0, rx_data is stored.
- R7: A slot strobe together with the frame strobe marks slot 0, and each further slot strobe advances one slot. tx_data changes only on the clock edge that samples a slot strobe, and it then holds the byte for that slot.
- R8: A connection word is laid out as bits [4:0] source channel, [6:5] source stream, [7] delay mode and [8] loopback. A write with cm_we high at a clock edge replaces the word of output stream cm_strm, channel cm_chan. After reset every word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_stb | input | 1 | One-cycle strobe per time slot |
| frame_stb | input | 1 | Marks slot 0, qualified by slot_stb |
| rx_data | input | NSTRM*DW | Received bytes for the current slot, stream s at [s*DW +: DW] |
| cm_we | input | 1 | Connection word write enable |
| cm_strm | input | SW | Output stream of the written word |
| cm_chan | input | CW | Output channel of the written word |
| cm_word | input | CMW | Connection word (layout in R8) |
| tx_data | output | NSTRM*DW | Transmitted bytes for the current slot, stream s at [s*DW +: DW] |

## Verification
The bench sweeps all 32 source-to-destination offsets in both modes. A design that put the variable-mode cut at n+2 or n+4 would deliver a slot one frame early or late. The directed entries cover the wrap corners: input slots 30 and 31 feeding output slots 0 and 1. A design that ignored them would read a bank still being written and return stale data. Looped-back channels are routed on to other outputs in both modes. If the transmit byte were taken one slot early, or taken at all with the bit clear, those outputs would differ. Strobes before framing is established, and idle cycles between strobes, are checked for a moving or non-zero output.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  typedef logic [1:0] bank_t;

  typedef enum logic {
    DLY_VAR   = 1'b0,
    DLY_CONST = 1'b1
  } dly_e;

  // frame bank rotation modulo 3
  function automatic bank_t bank_next(bank_t b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction

  function automatic bank_t bank_back(bank_t b, logic [1:0] k);
    logic [2:0] v;
    v = {1'b0, b} + 3'd3 - {1'b0, k};
    return (v >= 3'd3) ? 2'(v - 3'd3) : v[1:0];
  endfunction

endpackage

// File: rtl/tsi_frame_ctl.sv
module tsi_frame_ctl
  import tsi_pkg::*;
#(
  parameter  int NSLOT = 32,
  localparam int CW    = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot_stb,
  input  logic          frame_stb,
  output logic          act,
  output logic          synced,
  output logic [CW-1:0] wr_slot,
  output logic [CW-1:0] rd_slot,
  output bank_t         wr_bank,
  output bank_t         rd_frame_bank
);

  logic [CW-1:0] slot_q;
  bank_t         bank_q;
  logic          new_frame;
  logic          wrap;

  always_comb begin
    new_frame     = frame_stb || (slot_q == CW'(NSLOT - 1));
    act           = slot_stb && (synced || frame_stb);
    wr_slot       = new_frame ? '0 : slot_q + CW'(1);
    wr_bank       = new_frame ? bank_next(bank_q) : bank_q;
    // read runs two slots ahead of the write slot
    wrap          = (wr_slot >= CW'(NSLOT - 2));
    rd_slot       = wrap ? wr_slot - CW'(NSLOT - 2) : wr_slot + CW'(2);
    rd_frame_bank = wrap ? bank_next(wr_bank) : wr_bank;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= CW'(NSLOT - 1);
      bank_q <= 2'd2;
      synced <= 1'b0;
    end else if (act) begin
      slot_q <= wr_slot;
      bank_q <= wr_bank;
      synced <= 1'b1;
    end
  end

  // R7: a framed slot strobe always restarts numbering at slot 0
  a_r7_frame_slot0: assert property (@(posedge clk) disable iff (rst)
    (act && frame_stb) |=> (slot_q == '0));

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter  int NSTRM = 4,
  parameter  int NSLOT = 32,
  parameter  int CMW   = 9,
  localparam int SW    = $clog2(NSTRM),
  localparam int CW    = $clog2(NSLOT),
  localparam int RW    = CMW - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [SW-1:0]       w_strm,
  input  logic [CW-1:0]       w_chan,
  input  logic [CMW-1:0]      w_word,
  input  logic [CW-1:0]       rd_slot,
  input  logic [CW-1:0]       lb_slot,
  output logic [NSTRM*RW-1:0] route,
  output logic [NSTRM-1:0]    lb
);

  logic [CMW-1:0] cm [NSTRM*NSLOT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSTRM * NSLOT; i++) cm[i] <= '0;
    end else if (we) begin
      cm[{w_strm, w_chan}] <= w_word;
    end
  end

  for (genvar s = 0; s < NSTRM; s++) begin : g_port
    assign route[s*RW +: RW] = cm[{SW'(s), rd_slot}][RW-1:0];
    assign lb[s]             = cm[{SW'(s), lb_slot}][CMW-1];
  end

endmodule

// File: rtl/tsi_path_sel.sv
module tsi_path_sel
  import tsi_pkg::*;
#(
  parameter  int NSLOT = 32,
  parameter  int SW    = 2,
  localparam int CW    = $clog2(NSLOT),
  localparam int RW    = CW + SW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [RW-1:0] route,
  input  logic [CW-1:0] rd_slot,
  input  logic [CW-1:0] wr_slot,
  input  bank_t         frame_bank,
  input  bank_t         wr_bank,
  output logic [SW-1:0] src_strm,
  output logic [CW-1:0] src_chan,
  output bank_t         src_bank
);

  dly_e        mode;
  logic [CW:0] d_ext;
  logic [CW:0] c_ext;
  logic [1:0]  back;

  always_comb begin
    src_chan = route[CW-1:0];
    src_strm = route[CW +: SW];
    mode     = dly_e'(route[RW-1]);
    d_ext    = {1'b0, rd_slot};
    c_ext    = {1'b0, src_chan};
    if (mode == DLY_CONST)                   back = 2'd2;
    else if (d_ext >= c_ext + (CW+1)'(3))    back = 2'd0;
    else if (c_ext <= d_ext + (CW+1)'(NSLOT - 3)) back = 2'd1;
    else                                     back = 2'd2;
    src_bank = bank_back(frame_bank, back);
  end

  // R3: a read from the bank under write only touches slots already stored
  a_r3_fresh_only: assert property (@(posedge clk) disable iff (rst)
    (en && src_bank == wr_bank) |-> (src_chan < wr_slot));

  // R5: constant-delay reads never hit the bank being filled
  a_r5_const_bank: assert property (@(posedge clk) disable iff (rst)
    (en && mode == DLY_CONST) |-> (src_bank != wr_bank));

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
#(
  parameter  int NSTRM = 4,
  parameter  int NSLOT = 32,
  parameter  int DW    = 8,
  localparam int SW    = $clog2(NSTRM),
  localparam int CW    = $clog2(NSLOT),
  localparam int DEPTH = 3 * NSLOT
) (
  input  logic                clk,
  input  logic                en,
  input  logic [CW-1:0]       wr_slot,
  input  bank_t               wr_bank,
  input  logic [NSTRM*DW-1:0] wr_data,
  input  logic [NSTRM*SW-1:0] rd_strm,
  input  logic [NSTRM*CW-1:0] rd_chan,
  input  logic [NSTRM*2-1:0]  rd_bank,
  output logic [NSTRM*DW-1:0] rd_q
);

  logic [DW-1:0] mem [NSTRM][DEPTH];

  // registered read returns the old word on a same-address write
  always_ff @(posedge clk) begin
    if (en) begin
      for (int s = 0; s < NSTRM; s++)
        mem[SW'(s)][{wr_bank, wr_slot}] <= wr_data[s*DW +: DW];
      for (int o = 0; o < NSTRM; o++)
        rd_q[o*DW +: DW] <= mem[rd_strm[o*SW +: SW]][{rd_bank[o*2 +: 2], rd_chan[o*CW +: CW]}];
    end
  end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter  int NSTRM = 4,
  parameter  int NSLOT = 32,
  parameter  int DW    = 8,
  localparam int SW    = $clog2(NSTRM),
  localparam int CW    = $clog2(NSLOT),
  localparam int RW    = CW + SW + 1,
  localparam int CMW   = RW + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                slot_stb,
  input  logic                frame_stb,
  input  logic [NSTRM*DW-1:0] rx_data,
  input  logic                cm_we,
  input  logic [SW-1:0]       cm_strm,
  input  logic [CW-1:0]       cm_chan,
  input  logic [CMW-1:0]      cm_word,
  output logic [NSTRM*DW-1:0] tx_data
);

  logic                act, synced;
  logic [CW-1:0]       wr_slot, rd_slot;
  bank_t               wr_bank, rd_frame_bank;
  logic [NSTRM*RW-1:0] route;
  logic [NSTRM-1:0]    lb;
  logic [NSTRM*SW-1:0] src_strm;
  logic [NSTRM*CW-1:0] src_chan;
  logic [NSTRM*2-1:0]  src_bank;
  logic [NSTRM*DW-1:0] rd_q, stage_b, wr_data;

  tsi_frame_ctl #(.NSLOT(NSLOT)) u_frame (
    .clk(clk), .rst(rst), .slot_stb(slot_stb), .frame_stb(frame_stb),
    .act(act), .synced(synced), .wr_slot(wr_slot), .rd_slot(rd_slot),
    .wr_bank(wr_bank), .rd_frame_bank(rd_frame_bank)
  );

  tsi_conn_mem #(.NSTRM(NSTRM), .NSLOT(NSLOT), .CMW(CMW)) u_conn (
    .clk(clk), .rst(rst), .we(cm_we), .w_strm(cm_strm), .w_chan(cm_chan),
    .w_word(cm_word), .rd_slot(rd_slot), .lb_slot(wr_slot),
    .route(route), .lb(lb)
  );

  for (genvar o = 0; o < NSTRM; o++) begin : g_out
    bank_t bnk;
    tsi_path_sel #(.NSLOT(NSLOT), .SW(SW)) u_sel (
      .clk(clk), .rst(rst), .en(act), .route(route[o*RW +: RW]),
      .rd_slot(rd_slot), .wr_slot(wr_slot), .frame_bank(rd_frame_bank),
      .wr_bank(wr_bank), .src_strm(src_strm[o*SW +: SW]),
      .src_chan(src_chan[o*CW +: CW]), .src_bank(bnk)
    );
    assign src_bank[o*2 +: 2] = bnk;
    // loopback stores the byte leaving on this stream in this slot
    assign wr_data[o*DW +: DW] = lb[o] ? stage_b[o*DW +: DW] : rx_data[o*DW +: DW];
  end

  tsi_data_mem #(.NSTRM(NSTRM), .NSLOT(NSLOT), .DW(DW)) u_data (
    .clk(clk), .en(act), .wr_slot(wr_slot), .wr_bank(wr_bank),
    .wr_data(wr_data), .rd_strm(src_strm), .rd_chan(src_chan),
    .rd_bank(src_bank), .rd_q(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_b <= '0;
      tx_data <= '0;
    end else if (act) begin
      stage_b <= rd_q;
      tx_data <= stage_b;
    end
  end

  // R1: reset clears the output
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (tx_data == '0));

  // R2: nothing leaves the block before framing starts
  a_r2_unframed_quiet: assert property (@(posedge clk) disable iff (rst)
    !synced |-> (tx_data == '0));

  // R7: output only moves on a slot strobe
  a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
    !slot_stb |=> $stable(tx_data));

endmodule

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS  = 4;
  localparam int NSL = 32;
  localparam int DW  = 8;

  // {out stream[15:14], out chan[13:9], word[8:0]}; word = {lb, mode, src stream, src chan}
  localparam logic [15:0] CONN_VEC [12] = '{
    {2'd0, 5'd3,  1'b0, 1'b0, 2'd1, 5'd0},   // R3 edge d = c+3
    {2'd0, 5'd2,  1'b0, 1'b0, 2'd1, 5'd0},   // R4 d = c+2
    {2'd0, 5'd0,  1'b0, 1'b0, 2'd1, 5'd31},  // R4 two frames
    {2'd0, 5'd1,  1'b0, 1'b0, 2'd2, 5'd30},  // R4 c = d+29
    {2'd0, 5'd4,  1'b0, 1'b0, 2'd2, 5'd30},  // R4 next frame
    {2'd0, 5'd31, 1'b0, 1'b1, 2'd0, 5'd0},   // R5 longest
    {2'd1, 5'd0,  1'b0, 1'b1, 2'd3, 5'd31},  // R5 shortest
    {2'd0, 5'd5,  1'b1, 1'b0, 2'd3, 5'd1},   // R6 loopback on s0 ch5
    {2'd1, 5'd9,  1'b0, 1'b0, 2'd0, 5'd5},   // R6 looped sample, variable
    {2'd1, 5'd6,  1'b0, 1'b1, 2'd0, 5'd5},   // R6 looped sample, constant
    {2'd1, 5'd2,  1'b0, 1'b0, 2'd2, 5'd31},  // R4 c = d+29
    {2'd1, 5'd1,  1'b0, 1'b0, 2'd2, 5'd31}   // R4 c = d+30
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_stb = 1'b0;
  logic frame_stb = 1'b0;
  logic [NS*DW-1:0] rx_data = '0;
  logic cm_we = 1'b0;
  logic [1:0] cm_strm = '0;
  logic [4:0] cm_chan = '0;
  logic [8:0] cm_word = '0;
  logic [NS*DW-1:0] tx_data;

  tsi_switch #(.NSTRM(NS), .NSLOT(NSL), .DW(DW)) u_tsi_switch (
    .clk(clk), .rst(rst), .slot_stb(slot_stb), .frame_stb(frame_stb),
    .rx_data(rx_data), .cm_we(cm_we), .cm_strm(cm_strm), .cm_chan(cm_chan),
    .cm_word(cm_word), .tx_data(tx_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  bit  tbl     = 1'b0;
  int  fr      = -1;
  int  sl      = 0;

  logic [8:0] cm_m [NS][NSL];
  logic [7:0] hist [4][NS][NSL];
  bit         hv   [4][NS][NSL];
  bit         hl   [4][NS][NSL];
  logic [7:0] p1v [NS], p2v [NS], nv [NS];
  bit         p1ok[NS], p2ok[NS], nok[NS];
  string      p1t [NS], p2t [NS], nt [NS];

  function automatic logic [7:0] val(int f, int s, int t);
    return 8'(f * 53 + s * 29 + t * 7 + 11);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic prog(int o, int c, logic [8:0] w);
    @(negedge clk);
    cm_we = 1'b1; cm_strm = 2'(o); cm_chan = 5'(c); cm_word = w;
    cm_m[o][c] = w;
    @(negedge clk);
    cm_we = 1'b0;
  endtask

  // expected behaviour per slot, written from R3..R6
  task automatic model_step();
    int d, ff, k, src_f, c, ss;
    logic [8:0] w;
    for (int s = 0; s < NS; s++) begin
      nv[s] = p2v[s]; nok[s] = p2ok[s]; nt[s] = p2t[s];
    end
    for (int s = 0; s < NS; s++) begin
      hl[fr%4][s][sl] = cm_m[s][sl][8];
      if (cm_m[s][sl][8]) begin
        hist[fr%4][s][sl] = nv[s]; hv[fr%4][s][sl] = nok[s];
      end else begin
        hist[fr%4][s][sl] = val(fr, s, sl); hv[fr%4][s][sl] = 1'b1;
      end
    end
    d  = (sl + 2) % NSL;
    ff = fr + ((sl >= NSL - 2) ? 1 : 0);
    for (int o = 0; o < NS; o++) begin
      w  = cm_m[o][d];
      c  = int'(w[4:0]);
      ss = int'(w[6:5]);
      if (w[7])               k = 2;
      else if (d >= c + 3)    k = 0;
      else if (c <= d + 29)   k = 1;
      else                    k = 2;
      src_f = ff - k;
      p2v[o] = p1v[o]; p2ok[o] = p1ok[o]; p2t[o] = p1t[o];
      if (src_f < 0) begin
        p1ok[o] = 1'b0; p1v[o] = '0;
      end else begin
        p1ok[o] = hv[src_f%4][ss][c];
        p1v[o]  = hist[src_f%4][ss][c];
      end
      p1t[o] = hl[(src_f < 0) ? 0 : src_f%4][ss][c] && src_f >= 0 ? "R6" :
               w[7] ? "R5" : (k == 0) ? "R3" : "R4";
      if (tbl) p1t[o] = {"R8 ", p1t[o]};
    end
  endtask

  task automatic slot_step(bit fs);
    logic [NS*DW-1:0] seen;
    @(negedge clk);
    if (fs) begin fr = fr + 1; sl = 0; end else sl = sl + 1;
    slot_stb = 1'b1; frame_stb = fs;
    for (int s = 0; s < NS; s++) rx_data[s*DW +: DW] = val(fr, s, sl);
    model_step();
    @(negedge clk);
    slot_stb = 1'b0; frame_stb = 1'b0;
    seen = tx_data;
    for (int s = 0; s < NS; s++)
      if (nok[s]) chk($sformatf("%s stream %0d frame %0d slot %0d", nt[s], s, fr, sl),
                      32'(seen[s*DW +: DW]), 32'(nv[s]));
    @(negedge clk);
    chk("R7 hold between strobes", 32'(tx_data), 32'(seen));
  endtask

  task automatic run_frame();
    slot_step(1'b1);
    for (int t = 1; t < NSL; t++) slot_step(1'b0);
  endtask

  initial begin
    for (int o = 0; o < NS; o++)
      for (int c = 0; c < NSL; c++) cm_m[o][c] = '0;
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < NS; s++)
        for (int c = 0; c < NSL; c++) begin hv[b][s][c] = 1'b0; hl[b][s][c] = 1'b0; hist[b][s][c] = '0; end
    for (int s = 0; s < NS; s++) begin p1ok[s] = 1'b0; p2ok[s] = 1'b0; p1v[s] = '0; p2v[s] = '0; end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 output after reset", 32'(tx_data), 32'h0);

    // R2: strobes before framing are ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      slot_stb = 1'b1;
      rx_data = {NS*DW{1'b1}};
      @(negedge clk);
      slot_stb = 1'b0;
      chk("R2 unframed strobe", 32'(tx_data), 32'h0);
    end

    // R8 and directed corners from the table
    tbl = 1'b1;
    for (int i = 0; i < 12; i++)
      prog(int'(CONN_VEC[i][15:14]), int'(CONN_VEC[i][13:9]), CONN_VEC[i][8:0]);
    for (int f = 0; f < 5; f++) run_frame();
    tbl = 1'b0;

    // every offset, both modes: stream 2 variable from stream 1, stream 3 constant from stream 3
    for (int off = 0; off < NSL; off++) begin
      for (int d = 0; d < NSL; d++) begin
        prog(2, d, {1'b0, 1'b0, 2'd1, 5'((d - off + NSL) % NSL)});
        prog(3, d, {1'b0, 1'b1, 2'd3, 5'((d - off + NSL) % NSL)});
      end
      for (int f = 0; f < 2; f++) run_frame();
    end

    // R1 reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 output after mid-run reset", 32'(tx_data), 32'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule